// File: doc/BRIEF.md
# Banked Host Register Front End

This block is the host-facing register front end of a multi-channel line interface. The host reaches it over a non-multiplexed parallel bus. The bus has a 5-bit address, an 8-bit write path, a registered read path and separate active-low read and write strobes. One fixed address (1Fh) holds a bank selector. Its value steers every other address into one of four register banks: primary, secondary, per-channel and test-counter. After reset the selector is zero, so software that never touches it sees only the primary bank. That primary bank keeps the legacy layout.

The block latches per-channel events into a status byte in the primary bank. It also latches the test engine's status into a second status byte in the test-counter bank. The enabled bits of both status bytes are combined into one interrupt line. Status is cleared on read by default. A configuration bit switches the clearing to write-one-to-clear. The test-counter bank also exposes two 32-bit counters, one byte per address. Reading the lowest error-count byte takes a coherent snapshot of all eight counter bytes. The line-side logic, the pattern engine and the clock synthesis lie outside this block. They reach it only as event and counter inputs and as flat control-register outputs.

Top module: `banked_rf_ctrl`

## Requirements
- R1: After reset the selector at 1Fh reads 00h, `irq_o` is 0, and `rdata_oe_o` is 0.
- R2: Address 1Fh reads and writes the selector whatever bank is selected. Selector values pick the banks as follows: 00h primary, AAh secondary, 01h per-channel, 02h test-counter.
- R3: The same address in different banks names different registers. A write through one bank leaves the other banks' registers unchanged.
- R4: While the selector holds any other code, every address except 1Fh reads 00h and ignores writes.
- R5: In the primary bank, addresses 00h–0Fh and 11h–15h are read/write. Addresses 16h–1Eh read 00h and ignore writes.
- R6: A write takes effect at the first clock on which `wr_ni` is seen high after being low. The write uses `addr_i`/`wdata_i` as they stand at that clock. Holding `wr_ni` low writes nothing.
- R7: `rdata_oe_o` is 1 only while `rd_ni` is low after the read has been registered. `rdata_o` is 00h whenever `rdata_oe_o` is 0. The read value is taken at the first clock on which `rd_ni` is seen low.
- R8: Primary address 10h holds channel status. Bit n is set by `chan_evt_i[n]`. Primary 11h is the channel interrupt mask. `irq_o` is the OR of the channel status ANDed with 11h and the test latched status ANDed with the test enable.
- R9: In clear-on-read mode (the default), the status bits that a read returned are cleared when `rd_ni` rises.
- R10: Per-channel bank address 1Eh bit 0 = 1 selects clear-on-write. In that mode a read of a status register does not clear it. A write clears the bits written as 1.
- R11: A status bit whose event is present in the same cycle as its clear remains set.
- R12: In the test-counter bank, 0Ch reads the live test status `tst_live_i`. 0Eh holds that status latched and clears under the same mode as the channel status. 10h is the test interrupt enable.
- R13: In the test-counter bank, the error count sits at 14h–17h and the bit count at 18h–1Bh, least significant byte at the lowest address. A read of 14h returns the live error-count byte 0 and snapshots both counters. 15h–17h and 18h–1Bh return bytes of that snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Host address |
| wdata_i | input | 8 | Host write data |
| wr_ni | input | 1 | Write strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| rdata_o | output | 8 | Read data, 00h when not driven |
| rdata_oe_o | output | 1 | Enable for the external tri-state read-data driver |
| chan_evt_i | input | NCH | Per-channel interrupt events |
| tst_live_i | input | 8 | Live status of the test engine |
| err_cnt_i | input | CNT_W | Live bit-error count |
| bit_cnt_i | input | CNT_W | Live received-bit count |
| pri_regs_o | output | 248 | Primary bank registers, byte k at bits 8k+7:8k |
| sec_regs_o | output | 248 | Secondary bank registers |
| chn_regs_o | output | 248 | Per-channel bank registers |
| tst_regs_o | output | 248 | Test-counter bank read/write registers |
| irq_o | output | 1 | Combined interrupt |

## Verification
A status clear from the host and a new event on the same status bit can land in the same clock. The bench provokes this by holding a channel event line, or the test live status, high across the whole strobe. The strobe's rising edge, which carries the clear, therefore meets an active event. The test is run in both clear modes. A read-back after the strobe must still show the bit set. A second clear after the event is released must leave the bit at zero.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int NREG = 31;

  typedef enum logic [2:0] {BK_PRI, BK_SEC, BK_CHN, BK_TST, BK_NONE} bank_e;

  localparam logic [DW-1:0] SEL_PRI = 8'h00;
  localparam logic [DW-1:0] SEL_SEC = 8'hAA;
  localparam logic [DW-1:0] SEL_CHN = 8'h01;
  localparam logic [DW-1:0] SEL_TST = 8'h02;

  localparam logic [AW-1:0] A_SEL     = 5'h1F;
  localparam logic [AW-1:0] A_CSTAT   = 5'h10;
  localparam logic [AW-1:0] A_CMASK   = 5'h11;
  localparam logic [AW-1:0] A_CLRMODE = 5'h1E;
  localparam logic [AW-1:0] A_TLIVE   = 5'h0C;
  localparam logic [AW-1:0] A_TLATCH  = 5'h0E;
  localparam logic [AW-1:0] A_TIEN    = 5'h10;
  localparam logic [AW-1:0] A_ERR0    = 5'h14;
  localparam logic [AW-1:0] A_BIT0    = 5'h18;

  // which addresses hold plain read/write storage per bank
  localparam logic [NREG-1:0] MASK_PRI = 31'h003E_FFFF;
  localparam logic [NREG-1:0] MASK_SEC = 31'h0000_007B;
  localparam logic [NREG-1:0] MASK_CHN = 31'h4079_00FF;
  localparam logic [NREG-1:0] MASK_TST = 31'h0001_01FD;

  function automatic bank_e decode_sel(logic [DW-1:0] sel);
    case (sel)
      SEL_PRI: return BK_PRI;
      SEL_SEC: return BK_SEC;
      SEL_CHN: return BK_CHN;
      SEL_TST: return BK_TST;
      default: return BK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/banked_rf_strobe.sv
module banked_rf_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_ni,
  input  logic rd_ni,
  output logic wr_evt_o,
  output logic rd_start_o,
  output logic rd_end_o
);
  logic wr_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      rd_q <= 1'b1;
    end else begin
      wr_q <= wr_ni;
      rd_q <= rd_ni;
    end
  end

  assign wr_evt_o   = !wr_q && wr_ni;
  assign rd_start_o = rd_q && !rd_ni;
  assign rd_end_o   = !rd_q && rd_ni;
endmodule

// File: rtl/banked_rf_regs.sv
module banked_rf_regs #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int NREG = 31,
  parameter logic [NREG-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (MASK[g]) begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && waddr_i == AW'(g)) q <= wdata_i;
      end
      assign regs_o[g*DW +: DW] = q;
    end else begin : g_hole
      assign regs_o[g*DW +: DW] = '0;
    end
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_o));
endmodule

// File: rtl/banked_rf_sticky.sv
module banked_rf_sticky #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_o <= '0;
    else         stat_o <= (stat_o & ~clr_i) | set_i;
  end

  assert_set_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (stat_o & $past(set_i)) == $past(set_i));

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~set_i) != '0 |=> (stat_o & $past(clr_i & ~set_i)) == '0);
endmodule

// File: rtl/banked_rf_ctrl.sv
module banked_rf_ctrl
  import banked_rf_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [4:0]         addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               wr_ni,
  input  logic               rd_ni,
  output logic [7:0]         rdata_o,
  output logic               rdata_oe_o,
  input  logic [NCH-1:0]     chan_evt_i,
  input  logic [7:0]         tst_live_i,
  input  logic [CNT_W-1:0]   err_cnt_i,
  input  logic [CNT_W-1:0]   bit_cnt_i,
  output logic [247:0]       pri_regs_o,
  output logic [247:0]       sec_regs_o,
  output logic [247:0]       chn_regs_o,
  output logic [247:0]       tst_regs_o,
  output logic               irq_o
);
  localparam int CNT_B = CNT_W / DW;

  logic wr_evt, rd_start, rd_end;
  logic [DW-1:0] sel_q;
  bank_e bank;
  logic is_sel;

  banked_rf_strobe i_strobe (
    .clk_i, .rst_ni, .wr_ni, .rd_ni,
    .wr_evt_o(wr_evt), .rd_start_o(rd_start), .rd_end_o(rd_end)
  );

  assign bank   = decode_sel(sel_q);
  assign is_sel = (addr_i == A_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= SEL_PRI;
    else if (wr_evt && is_sel) sel_q <= wdata_i;
  end

  // per-bank storage
  logic [NREG*DW-1:0] bank_regs [4];
  localparam logic [NREG-1:0] BANK_MASK [4] = '{MASK_PRI, MASK_SEC, MASK_CHN, MASK_TST};

  for (genvar b = 0; b < 4; b++) begin : g_bank
    logic we;
    assign we = wr_evt && !is_sel && (bank == bank_e'(b));
    banked_rf_regs #(.AW(AW), .DW(DW), .NREG(NREG), .MASK(BANK_MASK[b])) i_regs (
      .clk_i, .rst_ni, .we_i(we), .waddr_i(addr_i), .wdata_i, .regs_o(bank_regs[b])
    );
  end

  assign pri_regs_o = bank_regs[0];
  assign sec_regs_o = bank_regs[1];
  assign chn_regs_o = bank_regs[2];
  assign tst_regs_o = bank_regs[3];

  logic clr_on_wr;
  logic [DW-1:0] cmask, tien;
  assign clr_on_wr = bank_regs[2][int'(A_CLRMODE)*DW];
  assign cmask     = bank_regs[0][int'(A_CMASK)*DW +: DW];
  assign tien      = bank_regs[3][int'(A_TIEN)*DW +: DW];

  // read capture
  logic [DW-1:0] rd_mux, rd_val_q;
  logic [AW-1:0] rd_addr_q;
  bank_e rd_bank_q;
  logic oe_q;
  logic [CNT_W-1:0] snap_err, snap_bit;
  logic [NCH-1:0] cstat;
  logic [DW-1:0] tlat;

  function automatic logic [DW-1:0] pick(logic [NREG*DW-1:0] v, logic [AW-1:0] a);
    return v[int'(a)*DW +: DW];
  endfunction

  always_comb begin
    rd_mux = '0;
    if (is_sel) rd_mux = sel_q;
    else begin
      case (bank)
        BK_PRI: rd_mux = (addr_i == A_CSTAT) ? DW'(cstat) : pick(bank_regs[0], addr_i);
        BK_SEC: rd_mux = pick(bank_regs[1], addr_i);
        BK_CHN: rd_mux = pick(bank_regs[2], addr_i);
        BK_TST: begin
          rd_mux = pick(bank_regs[3], addr_i);
          if (addr_i == A_TLIVE)  rd_mux = tst_live_i;
          if (addr_i == A_TLATCH) rd_mux = tlat;
          for (int k = 0; k < CNT_B; k++) begin
            if (addr_i == A_ERR0 + AW'(k))
              rd_mux = (k == 0) ? err_cnt_i[DW-1:0] : snap_err[k*DW +: DW];
            if (addr_i == A_BIT0 + AW'(k))
              rd_mux = snap_bit[k*DW +: DW];
          end
        end
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_val_q  <= '0;
      rd_addr_q <= '0;
      rd_bank_q <= BK_PRI;
      oe_q      <= 1'b0;
      snap_err  <= '0;
      snap_bit  <= '0;
    end else begin
      if (rd_start) begin
        rd_val_q  <= rd_mux;
        rd_addr_q <= addr_i;
        rd_bank_q <= is_sel ? BK_NONE : bank;
        oe_q      <= 1'b1;
        if (!is_sel && bank == BK_TST && addr_i == A_ERR0) begin
          snap_err <= err_cnt_i;
          snap_bit <= bit_cnt_i;
        end
      end else if (rd_end) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign rdata_oe_o = oe_q && !rd_ni;
  assign rdata_o    = rdata_oe_o ? rd_val_q : '0;

  // status clear steering
  logic c_wr_hit, c_rd_hit, t_wr_hit, t_rd_hit;
  logic [NCH-1:0] cstat_clr;
  logic [DW-1:0]  tlat_clr;

  assign c_wr_hit = wr_evt && !is_sel && bank == BK_PRI && addr_i == A_CSTAT;
  assign t_wr_hit = wr_evt && !is_sel && bank == BK_TST && addr_i == A_TLATCH;
  assign c_rd_hit = rd_end && rd_bank_q == BK_PRI && rd_addr_q == A_CSTAT;
  assign t_rd_hit = rd_end && rd_bank_q == BK_TST && rd_addr_q == A_TLATCH;

  always_comb begin
    if (clr_on_wr) begin
      cstat_clr = c_wr_hit ? wdata_i[NCH-1:0] : '0;
      tlat_clr  = t_wr_hit ? wdata_i : '0;
    end else begin
      cstat_clr = c_rd_hit ? rd_val_q[NCH-1:0] : '0;
      tlat_clr  = t_rd_hit ? rd_val_q : '0;
    end
  end

  banked_rf_sticky #(.W(NCH)) i_chan_stat (
    .clk_i, .rst_ni, .set_i(chan_evt_i), .clr_i(cstat_clr), .stat_o(cstat)
  );

  banked_rf_sticky #(.W(DW)) i_tst_stat (
    .clk_i, .rst_ni, .set_i(tst_live_i), .clr_i(tlat_clr), .stat_o(tlat)
  );

  assign irq_o = |(cstat & cmask[NCH-1:0]) || |(tlat & tien);

  assert_sel_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_evt && is_sel) |=> $stable(sel_q));

  assert_no_bank_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start && bank == BK_NONE && !is_sel |=> rd_val_q == '0);

  assert_snapshot_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start && bank == BK_TST && addr_i == A_ERR0 && !is_sel
      |=> snap_err == $past(err_cnt_i) && snap_bit == $past(bit_cnt_i));

  assert_oe_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_end |=> !oe_q);
endmodule

// File: tb/test_banked_rf_ctrl.sv
module test_banked_rf_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_ni = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr_n = 1, rd_n = 1;
  logic [7:0] rdata;
  logic oe, irq;
  logic [7:0] chan_evt = 0, tst_live = 0;
  logic [31:0] err_cnt = 0, bit_cnt = 0;
  logic [247:0] pri, sec, chn, tst;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_rf_ctrl i_banked_rf_ctrl (
    .clk_i(clk), .rst_ni, .addr_i(addr), .wdata_i(wdata), .wr_ni(wr_n), .rd_ni(rd_n),
    .rdata_o(rdata), .rdata_oe_o(oe), .chan_evt_i(chan_evt), .tst_live_i(tst_live),
    .err_cnt_i(err_cnt), .bit_cnt_i(bit_cnt), .pri_regs_o(pri), .sec_regs_o(sec),
    .chn_regs_o(chn), .tst_regs_o(tst), .irq_o(irq)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_n = 0;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse_chan(input logic [7:0] v);
    @(negedge clk); chan_evt = v;
    @(negedge clk); chan_evt = 0;
  endtask

  // monitor: one registered read value per strobe
  initial forever begin
    @(posedge clk); #1;
    if (oe) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7: unexpected drive actual=%h expected=none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk({7'b0, oe}, 8'h00, "R1 oe after reset");
    chk({7'b0, irq}, 8'h00, "R1 irq after reset");
    rd(5'h1F, 8'h00, "R1 selector reset");

    // R3 bank separation, R2 selector
    wr(5'h00, 8'h5A);
    rd(5'h00, 8'h5A, "R3 primary 00");
    wr(5'h1F, 8'hAA);
    rd(5'h1F, 8'hAA, "R2 selector in secondary");
    wr(5'h00, 8'hC3);
    rd(5'h00, 8'hC3, "R3 secondary 00");
    wr(5'h1F, 8'h00);
    rd(5'h00, 8'h5A, "R3 primary kept");
    wr(5'h1F, 8'h01);
    wr(5'h03, 8'h3C);
    rd(5'h03, 8'h3C, "R2 per-channel bank");
    wr(5'h1F, 8'h00);
    rd(5'h03, 8'h00, "R3 primary 03 untouched");

    // R5 primary map
    wr(5'h15, 8'h77);
    rd(5'h15, 8'h77, "R5 primary 15");
    wr(5'h16, 8'hFF);
    rd(5'h16, 8'h00, "R5 reserved 16");
    wr(5'h1E, 8'h11);
    rd(5'h1E, 8'h00, "R5 reserved 1E");

    // R4 undefined selector code
    wr(5'h1F, 8'h55);
    rd(5'h1F, 8'h55, "R2 selector undefined code");
    rd(5'h00, 8'h00, "R4 read under undefined code");
    wr(5'h00, 8'h99);
    wr(5'h1F, 8'h00);
    rd(5'h00, 8'h5A, "R4 primary not written");
    wr(5'h1F, 8'hAA);
    rd(5'h00, 8'hC3, "R4 secondary not written");
    wr(5'h1F, 8'h00);

    // R6 write on strobe release only
    @(negedge clk); addr = 5'h02; wdata = 8'hCD; wr_n = 0;
    repeat (3) @(negedge clk);
    rd(5'h02, 8'h00, "R6 held-low strobe");
    @(negedge clk); wr_n = 1;
    @(negedge clk);
    rd(5'h02, 8'hCD, "R6 written at release");

    // R7 drive window
    chk({7'b0, oe}, 8'h00, "R7 oe idle");
    chk(rdata, 8'h00, "R7 rdata idle");

    // R8/R9 channel status, clear-on-read
    wr(5'h11, 8'h05);
    pulse_chan(8'h03);
    @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R8 irq on masked bit");
    rd(5'h10, 8'h03, "R8 status latched");
    chk({7'b0, irq}, 8'h00, "R9 irq after read clear");
    rd(5'h10, 8'h00, "R9 status cleared");
    pulse_chan(8'h02);
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R8 unmasked bit no irq");
    rd(5'h10, 8'h02, "R8 status bit1");

    // R11 in clear-on-read
    @(negedge clk); chan_evt = 8'h04;
    rd(5'h10, 8'h04, "R11 read with event held");
    rd(5'h10, 8'h04, "R11 bit survives read clear");
    @(negedge clk); chan_evt = 0;
    rd(5'h10, 8'h04, "R11 last value");
    rd(5'h10, 8'h00, "R11 cleared after release");

    // R10 clear-on-write
    wr(5'h1F, 8'h01); wr(5'h1E, 8'h01); wr(5'h1F, 8'h00);
    pulse_chan(8'h01);
    @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R10 irq set");
    rd(5'h10, 8'h01, "R10 read");
    rd(5'h10, 8'h01, "R10 read does not clear");
    wr(5'h10, 8'h00);
    rd(5'h10, 8'h01, "R10 zero write keeps");
    wr(5'h10, 8'h01);
    rd(5'h10, 8'h00, "R10 one write clears");
    chk({7'b0, irq}, 8'h00, "R10 irq cleared");
    @(negedge clk); chan_evt = 8'h04;
    wr(5'h10, 8'h04);
    @(negedge clk); chan_evt = 0;
    rd(5'h10, 8'h04, "R11 write clear with event");
    wr(5'h10, 8'h04);
    rd(5'h10, 8'h00, "R11 write clear after release");
    wr(5'h1F, 8'h01); wr(5'h1E, 8'h00);

    // R12 test status
    wr(5'h1F, 8'h02);
    wr(5'h00, 8'h12);
    rd(5'h00, 8'h12, "R2 test bank rw");
    @(negedge clk); tst_live = 8'h81;
    rd(5'h0C, 8'h81, "R12 live status");
    @(negedge clk); tst_live = 0;
    rd(5'h0C, 8'h00, "R12 live follows input");
    rd(5'h0E, 8'h81, "R12 latched status");
    rd(5'h0E, 8'h00, "R12 latched cleared on read");
    wr(5'h10, 8'h01);
    rd(5'h10, 8'h01, "R12 enable reg");
    @(negedge clk); tst_live = 8'h80;
    @(negedge clk); tst_live = 0;
    @(negedge clk);
    chk({7'b0, irq}, 8'h00, "R12 disabled bit no irq");
    @(negedge clk); tst_live = 8'h01;
    @(negedge clk); tst_live = 0;
    @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R12 enabled bit irq");
    rd(5'h0E, 8'h81, "R12 latched both");
    chk({7'b0, irq}, 8'h00, "R12 irq cleared");

    // R13 counters with snapshot
    @(negedge clk); err_cnt = 32'h1122_3344; bit_cnt = 32'hA0B0_C0D0;
    rd(5'h14, 8'h44, "R13 err byte0 live");
    @(negedge clk); err_cnt = 32'hFFFF_FFFF; bit_cnt = 32'h0;
    rd(5'h15, 8'h33, "R13 err byte1 snap");
    rd(5'h16, 8'h22, "R13 err byte2 snap");
    rd(5'h17, 8'h11, "R13 err byte3 snap");
    rd(5'h18, 8'hD0, "R13 bit byte0 snap");
    rd(5'h19, 8'hC0, "R13 bit byte1 snap");
    rd(5'h1A, 8'hB0, "R13 bit byte2 snap");
    rd(5'h1B, 8'hA0, "R13 bit byte3 snap");
    rd(5'h14, 8'hFF, "R13 new snapshot");
    rd(5'h17, 8'hFF, "R13 new snap byte3");
    rd(5'h1B, 8'h00, "R13 new bit byte3");

    repeat (3) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R7 every read driven");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule